// File: doc/BRIEF.md
# Dual-Port Edge-Detecting Interrupt Bank

This block gathers up to 32 interrupt sources and reports them to two independent hosts. Every source passes through a two-flop synchroniser and an edge detector. A two-bit code, set per source, picks rising edges, falling edges, both, or neither. A detected event is latched into a status register that each host owns. Each host also has its own mask register and its own active-low interrupt line. The edge configuration is a single copy that both hosts share.

Software reaches the block through a byte-wide register port, with separate read and write strobes and a combinational read path. A control register selects how status is cleared, either by reading it or by writing ones to it. The same register decides whether a second event that arrives while a status bit is still set is held back and re-raised once that bit is cleared. Each host also has a write-only test register that forces status bits directly.

Top module: `irq_edge_bank`

## Requirements
- R1: After reset, every status bit is 0, every valid mask bit is 1, all edge codes and the control register are 0, and both `irq_n` lines are high.
- R2: The edge code of source i sits in edge byte i/4 at bits (i mod 4)*2+1:(i mod 4)*2. Bit (i mod 4)*2+1 enables rising edges and bit (i mod 4)*2 enables falling edges. An enabled input change driven before clock edge k shows in status after clock edge k+2.
- R3: A source whose edge code is 00 never sets a status bit, on either port, for either input transition.
- R4: A detected event sets the source's status bit on both ports. `irq_n[p]` is low exactly when port p's status AND NOT its mask is nonzero, and each port's mask acts only on that port.
- R5: With control bit 0 set, a read of a status byte returns its current bits and clears them.
- R6: With control bit 0 clear, a read leaves status unchanged, and writing a 1 to a status bit clears it.
- R7: With control bit 1 clear, an event on a source whose status bit is already set is held, and the bit stays set after the next clear. A further clear removes it. With control bit 1 set, one clear is enough.
- R8: When an edge event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R9: Writing ones to a port's test byte sets those status bits on that port only. Test bytes read as zero.
- R10: Address map: 0x00 control, 0x08-0x0F edge codes, 0x10-0x13 status port 0, 0x14-0x17 mask port 0, 0x18-0x1B status port 1, 0x1C-0x1F mask port 1, 0x20-0x23 test port 0, 0x24-0x27 test port 1. Multi-byte registers are little-endian. Unmapped addresses read zero.
- R11: Status and mask registers span ceil(N/8) bytes and edge codes span ceil(2N/8) bytes. Bits at or above N (or 2N for edge codes) read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | NSRC | Asynchronous interrupt source inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives clear-on-read) |
| reg_addr | input | 6 | Byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_n | output | 2 | Active-low interrupt line per port |

## Verification
The bench builds the block with NSRC = 10. At that size both the status bytes and the edge bytes end in a partial byte, so the bits above N can be seen reading back as zero. The size is also small enough that every source can be driven with all four edge codes, each in both directions. At each point the bench checks both ports' status and both interrupt lines. The clear modes, the pending buffer, same-cycle edge against clear, and the test registers are then driven on single sources at cycle-exact timing.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;
    localparam int unsigned ADDR_W = 6;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 6'h00;
    localparam logic [2:0]        PAGE_EDGE = 3'b001;   // 0x08..0x0F
    localparam logic [3:0]        QUAD_STAT = 4'h4;     // + 2*port
    localparam logic [3:0]        QUAD_MASK = 4'h5;     // + 2*port
    localparam logic [3:0]        QUAD_TEST = 4'h8;     // + port

    typedef struct packed {
        logic pend_dis;   // bit 1
        logic cor;        // bit 0
    } ctrl_t;
endpackage

// File: rtl/irqbank_edge.sv
module irqbank_edge #(
    parameter int unsigned NSRC = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_in,
    input  logic [2*NSRC-1:0] edge_cfg,
    output logic [NSRC-1:0]   hit
);
    typedef struct packed {
        logic [NSRC-1:0] meta;
        logic [NSRC-1:0] sync;
        logic [NSRC-1:0] prev;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic [NSRC-1:0] rise_en, fall_en;

    for (genvar i = 0; i < NSRC; i++) begin : g_cfg
        assign rise_en[i] = edge_cfg[2*i+1];
        assign fall_en[i] = edge_cfg[2*i];
    end

    always_comb begin
        st_d      = st_q;
        st_d.meta = src_in;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
        hit       = (st_q.sync & ~st_q.prev & rise_en) |
                    (~st_q.sync & st_q.prev & fall_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irqbank_port.sv
module irqbank_port #(
    parameter int unsigned NSRC = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] hit,
    input  logic            sel_stat,
    input  logic            sel_mask,
    input  logic            sel_test,
    input  logic            reg_rd,
    input  logic            reg_wr,
    input  logic [1:0]      byte_idx,
    input  logic [7:0]      wdata,
    input  logic            cor,
    input  logic            pend_dis,
    output logic [NSRC-1:0] stat,
    output logic [NSRC-1:0] mask,
    output logic            irq_n
);
    typedef struct packed {
        logic [NSRC-1:0] stat;
        logic [NSRC-1:0] mask;
        logic [NSRC-1:0] pend;
    } port_st_t;

    port_st_t st_d, st_q;
    logic [NSRC-1:0] lane, wbits, clr, set;

    always_comb begin
        st_d  = st_q;
        lane  = NSRC'(32'h0000_00FF << {byte_idx, 3'b000});
        wbits = NSRC'({24'd0, wdata} << {byte_idx, 3'b000});

        clr = '0;
        if (sel_stat) begin
            if (cor) clr = reg_rd ? lane : '0;
            else     clr = reg_wr ? (lane & wbits) : '0;
        end
        set = hit | ((sel_test && reg_wr) ? (lane & wbits) : '0);

        // an event wins over a clear; a held event re-raises a cleared bit
        st_d.stat = set | (st_q.stat & ~clr) | (clr & st_q.pend);
        st_d.pend = (st_q.pend & (~clr | set)) |
                    (~st_q.pend & set & st_q.stat & ~clr);
        if (pend_dis) st_d.pend = '0;

        if (sel_mask && reg_wr)
            st_d.mask = (st_q.mask & ~lane) | (wbits & lane);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stat <= '0;
            st_q.mask <= '1;
            st_q.pend <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat  = st_q.stat;
    assign mask  = st_q.mask;
    assign irq_n = ~|(st_q.stat & ~st_q.mask);
endmodule

// File: rtl/irq_edge_bank.sv
module irq_edge_bank
    import irqbank_pkg::*;
#(
    parameter int unsigned NSRC = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_in,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [1:0]        irq_n
);
    localparam int unsigned STAT_BYTES = (NSRC + 7) / 8;
    localparam int unsigned EDGE_BYTES = (2 * NSRC + 7) / 8;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [2*NSRC-1:0] edr;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NSRC-1:0]   hit;
    logic [2*NSRC-1:0] stat_all, mask_all;
    logic [2*NSRC-1:0] edr_w;
    logic              cor_w, pdis_w;

    assign edr_w  = st_q.edr;
    assign cor_w  = st_q.ctrl.cor;
    assign pdis_w = st_q.ctrl.pend_dis;

    irqbank_edge #(.NSRC(NSRC)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (src_in),
        .edge_cfg (st_q.edr),
        .hit      (hit)
    );

    for (genvar p = 0; p < 2; p++) begin : g_port
        logic sel_stat, sel_mask, sel_test;
        assign sel_stat = reg_addr[5:2] == 4'(QUAD_STAT + 2 * p);
        assign sel_mask = reg_addr[5:2] == 4'(QUAD_MASK + 2 * p);
        assign sel_test = reg_addr[5:2] == 4'(QUAD_TEST + p);

        irqbank_port #(.NSRC(NSRC)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit      (hit),
            .sel_stat (sel_stat),
            .sel_mask (sel_mask),
            .sel_test (sel_test),
            .reg_rd   (reg_rd),
            .reg_wr   (reg_wr),
            .byte_idx (reg_addr[1:0]),
            .wdata    (reg_wdata),
            .cor      (st_q.ctrl.cor),
            .pend_dis (st_q.ctrl.pend_dis),
            .stat     (stat_all[p*NSRC +: NSRC]),
            .mask     (mask_all[p*NSRC +: NSRC]),
            .irq_n    (irq_n[p])
        );
    end

    // control and shared edge codes
    always_comb begin
        logic [2*NSRC-1:0] elane, ebits;
        st_d  = st_q;
        elane = (2*NSRC)'(64'hFF << {reg_addr[2:0], 3'b000});
        ebits = (2*NSRC)'({56'd0, reg_wdata} << {reg_addr[2:0], 3'b000});
        if (reg_wr) begin
            if (reg_addr == ADDR_CTRL) begin
                st_d.ctrl.cor      = reg_wdata[0];
                st_d.ctrl.pend_dis = reg_wdata[1];
            end
            if (reg_addr[5:3] == PAGE_EDGE)
                st_d.edr = (st_q.edr & ~elane) | (ebits & elane);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read path
    always_comb begin
        logic [63:0] edr_pad;
        logic [31:0] stat_pad [2];
        logic [31:0] mask_pad [2];
        edr_pad     = 64'(st_q.edr);
        stat_pad[0] = 32'(stat_all[NSRC-1:0]);
        stat_pad[1] = 32'(stat_all[2*NSRC-1:NSRC]);
        mask_pad[0] = 32'(mask_all[NSRC-1:0]);
        mask_pad[1] = 32'(mask_all[2*NSRC-1:NSRC]);
        reg_rdata   = 8'h00;
        if (reg_addr == ADDR_CTRL) begin
            reg_rdata = {6'd0, st_q.ctrl.pend_dis, st_q.ctrl.cor};
        end else if (reg_addr[5:3] == PAGE_EDGE) begin
            if (32'(reg_addr[2:0]) < EDGE_BYTES)
                reg_rdata = edr_pad[{reg_addr[2:0], 3'b000} +: 8];
        end else if (32'(reg_addr[1:0]) < STAT_BYTES) begin
            unique case (reg_addr[5:2])
                4'h4:    reg_rdata = stat_pad[0][{reg_addr[1:0], 3'b000} +: 8];
                4'h5:    reg_rdata = mask_pad[0][{reg_addr[1:0], 3'b000} +: 8];
                4'h6:    reg_rdata = stat_pad[1][{reg_addr[1:0], 3'b000} +: 8];
                4'h7:    reg_rdata = mask_pad[1][{reg_addr[1:0], 3'b000} +: 8];
                default: reg_rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/irqbank_chk.sv
module irqbank_chk #(
    parameter int unsigned NSRC = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_rd,
    input logic            reg_wr,
    input logic [5:0]      reg_addr,
    input logic            wbit0,
    input logic [1:0]      irq_n,
    input logic            hit0,
    input logic            stat0_b0,
    input logic            stat1_b0,
    input logic [NSRC-1:0] mask0,
    input logic [NSRC-1:0] mask1,
    input logic [1:0]      edr0,
    input logic            cor,
    input logic            pdis
);
    AST_RESET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (&mask0 && &mask1 && !stat0_b0 && !stat1_b0)); // R1

    AST_CODE_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        hit0 |-> (edr0 != 2'b00)); // R3

    AST_BOTH_PORTS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        hit0 |=> (stat0_b0 && stat1_b0)); // R4

    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask0 && &mask1) |-> (irq_n == 2'b11)); // R4

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && cor && pdis && reg_addr == 6'h10 && !hit0)
            |=> !stat0_b0); // R5

    AST_WRITE_ONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !cor && pdis && reg_addr == 6'h10 && wbit0 && !hit0)
            |=> !stat0_b0); // R6

    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (hit0 && reg_wr && !cor && reg_addr == 6'h10 && wbit0)
            |=> stat0_b0); // R8
endmodule

bind irq_edge_bank irqbank_chk #(.NSRC(NSRC)) i_irqbank_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .wbit0    (reg_wdata[0]),
    .irq_n    (irq_n),
    .hit0     (hit[0]),
    .stat0_b0 (stat_all[0]),
    .stat1_b0 (stat_all[NSRC]),
    .mask0    (mask_all[NSRC-1:0]),
    .mask1    (mask_all[2*NSRC-1:NSRC]),
    .edr0     (edr_w[1:0]),
    .cor      (cor_w),
    .pdis     (pdis_w)
);

// File: tb/test_irq_edge_bank.sv
module test_irq_edge_bank;
    localparam int NS = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_in = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [5:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [1:0]    irq_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_edge_bank #(.NSRC(NS)) i_irq_edge_bank (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        tick();
        reg_rd = 1'b0;
    endtask

    task automatic clear_stat();
        wr(6'h10, 8'hFF); wr(6'h11, 8'hFF);
        wr(6'h18, 8'hFF); wr(6'h19, 8'hFF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] e;
        tick(3);
        rst_n = 1'b1;
        tick();

        // R1 reset state
        rd(6'h00, d); check("R1 ctrl", d, 8'h00);
        rd(6'h08, d); check("R1 edge", d, 8'h00);
        rd(6'h10, d); check("R1 stat0", d, 8'h00);
        rd(6'h14, d); check("R1 mask0 b0", d, 8'hFF);
        rd(6'h1C, d); check("R1 mask1 b0", d, 8'hFF);
        check("R1 irq_n", irq_n, 2'b11);

        // R11 partial bytes, R10 unmapped
        rd(6'h15, d); check("R11 mask0 b1", d, 8'h03);
        rd(6'h16, d); check("R11 mask0 b2", d, 8'h00);
        wr(6'h0A, 8'hFF); rd(6'h0A, d); check("R11 edge b2", d, 8'h0F);
        wr(6'h0B, 8'hFF); rd(6'h0B, d); check("R11 edge b3", d, 8'h00);
        wr(6'h0A, 8'h00);
        rd(6'h30, d); check("R10 unmapped", d, 8'h00);

        // R2/R3/R4 sweep: every source, every code, both directions
        wr(6'h00, 8'h02);                 // W1C, pending disabled
        wr(6'h14, 8'h00); wr(6'h15, 8'h00);
        for (int i = 0; i < NS; i++) begin
            for (int code = 0; code < 4; code++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    string tag;
                    tag = (code == 0) ? "R3" : "R2";
                    wr(6'h08, 8'h00); wr(6'h09, 8'h00); wr(6'h0A, 8'h00);
                    wr(6'(8 + i / 4), 8'(code << (2 * (i % 4))));
                    clear_stat();
                    src_in[i] = (dir == 0);
                    tick(4);
                    e = ((dir == 0) ? code[1] : code[0]) ? 8'(1 << (i % 8)) : 8'h00;
                    rd(6'(6'h10 + i / 8), d);
                    check($sformatf("%s src%0d code%0d dir%0d p0", tag, i, code, dir), d, e);
                    rd(6'(6'h18 + i / 8), d);
                    check($sformatf("R4 src%0d code%0d dir%0d p1", i, code, dir), d, e);
                    check($sformatf("R4 irq_n src%0d code%0d dir%0d", i, code, dir),
                          irq_n, {1'b1, (e == 8'h00)});
                end
            end
        end
        wr(6'h08, 8'h00); wr(6'h09, 8'h00); wr(6'h0A, 8'h00);
        clear_stat();

        // R4 per-port mask
        wr(6'h14, 8'hFF); wr(6'h15, 8'hFF);
        wr(6'h1C, 8'hFE);
        wr(6'h20, 8'h01); wr(6'h24, 8'h01);
        check("R4 mask per port", irq_n, 2'b01);
        clear_stat();
        check("R4 irq release", irq_n, 2'b11);

        // R2 latency: rising code on src 0
        wr(6'h08, 8'h02);
        src_in[0] = 1'b1;
        tick(2);
        rd(6'h10, d); check("R2 not yet after two edges", d, 8'h00);
        rd(6'h10, d); check("R2 set after third edge", d, 8'h01);
        src_in[0] = 1'b0; tick(4);
        clear_stat();

        // R9 test register per port, reads zero
        wr(6'h25, 8'hFF);
        rd(6'h19, d); check("R9 p1 byte1", d, 8'h03);
        rd(6'h11, d); check("R9 p0 untouched", d, 8'h00);
        rd(6'h25, d); check("R9 test reads zero", d, 8'h00);
        clear_stat();

        // R6 W1C: reads keep bits
        wr(6'h20, 8'h05);
        rd(6'h10, d); rd(6'h10, d); check("R6 read keeps", d, 8'h05);
        wr(6'h10, 8'h04);
        rd(6'h10, d); check("R6 write one clears", d, 8'h01);
        clear_stat();

        // R5 clear-on-read
        wr(6'h00, 8'h03);
        wr(6'h20, 8'h05);
        rd(6'h10, d); check("R5 first read", d, 8'h05);
        rd(6'h10, d); check("R5 second read", d, 8'h00);

        // R7 pending buffer on
        wr(6'h00, 8'h00);
        clear_stat();
        for (int k = 0; k < 2; k++) begin
            src_in[0] = 1'b1; tick(4);
            src_in[0] = 1'b0; tick(4);
        end
        wr(6'h10, 8'h01);
        rd(6'h10, d); check("R7 held event re-raised", d, 8'h01);
        wr(6'h10, 8'h01);
        rd(6'h10, d); check("R7 second clear", d, 8'h00);

        // R7 pending buffer off
        wr(6'h00, 8'h02);
        clear_stat();
        for (int k = 0; k < 2; k++) begin
            src_in[0] = 1'b1; tick(4);
            src_in[0] = 1'b0; tick(4);
        end
        wr(6'h10, 8'h01);
        rd(6'h10, d); check("R7 disabled one clear", d, 8'h00);

        // R8 edge and clear in the same cycle
        wr(6'h20, 8'h01);
        src_in[0] = 1'b1;
        tick(2);                         // detection active before third edge
        wr(6'h10, 8'h01);                // clear lands on that edge
        rd(6'h10, d); check("R8 edge wins", d, 8'h01);
        src_in[0] = 1'b0; tick(4);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule